// File: doc/BRIEF.md
# Timed Program-Pulse Sequence Guard

This block sits next to the test access port controller of an in-system-programmable device. It watches instruction-register update events and the controller state. From these it follows the pair of instructions that opens and closes a programming pulse. It requires a minimum number of idle-state clock cycles between the two. It also rejects instructions that may not be loaded while a pulse is open. Each outcome is written into a small status word, which the data-register path captures.

An instruction is classified when it is loaded, on the Update-IR event. It is carried out in the first following clock cycle that the controller spends in Run-Test/Idle. The status word and the pulse state change only in such cycles, or when the controller is reset. The non-volatile programming itself lies outside this block. The burn timer counts Run-Test/Idle cycles of the test clock.

Top module: `isc_pulse_guard`

## Requirements
- R1: An active-low asynchronous `trst_n`, or a cycle with `tap_tlr` high, sets `status` to 0, drops `pulse_active`, clears the burn timer and discards any loaded instruction that has not yet been carried out.
- R2: `status` changes only on a clock edge at which `tap_rti` is high and `ir_upd` is low, apart from the clearing in R1. A loaded instruction is carried out at the first such edge after its load.
- R3: Carrying out the start code (default 8'hE2) with `sec_fault` low writes status 5'b00001 (result 01, done 0, sub-code 0), raises `pulse_active` and restarts the burn count from zero.
- R4: Carrying out the start code with `sec_fault` high writes status 5'b11010 (sub-code 3, security) and leaves `pulse_active` low.
- R5: Carrying out the stop code (default 8'hE3) during a pulse, after at least MIN_BURN counted cycles, writes status 5'b00101 (result 01, done 1) and drops `pulse_active`.
- R6: Carrying out the stop code during a pulse with fewer than MIN_BURN counted cycles writes status 5'b01010 (sub-code 1, duration) and drops `pulse_active`.
- R7: Carrying out the stop code with no pulse open writes status 5'b10010 (sub-code 2, sequence).
- R8: During a pulse, loading the no-op (8'hE0), bypass (8'hFF), sample (8'h01) or external-test (8'h00) code leaves `status` and `pulse_active` unchanged. Every later Run-Test/Idle edge with nothing pending still counts toward the burn time.
- R9: During a pulse, loading any other code except stop, the start code included, is an error. The next Run-Test/Idle edge writes status 5'b10010 and drops `pulse_active`. The error stays pending even if a permitted code is loaded before that edge.
- R10: Bit 2 of `status` (done) is set at the Run-Test/Idle edge on which the burn count of an open pulse reaches MIN_BURN. The other status bits keep their values.
- R11: Outside a pulse, loading a code other than start or stop has no effect on `status`. A later load displaces a start or stop that has not yet been carried out.
- R12: Status layout: bits [1:0] hold the result (01 pass, 10 fail, never 11), bit 2 is the done flag, and bits [4:3] hold the sub-code. A pass result always has sub-code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tap_tlr | input | 1 | Controller is in Test-Logic-Reset |
| tap_rti | input | 1 | Controller is in Run-Test/Idle |
| ir_upd | input | 1 | Instruction register update strobe |
| ir_code | input | IR_W | Instruction code being loaded |
| sec_fault | input | 1 | Security violation seen for a start request |
| status | output | SUB_W+3 | Status word for data-register capture |
| pulse_active | output | 1 | A programming pulse is open |

## Verification
The bench targets the burn-time boundary: a stop one cycle early must give the duration sub-code, and the done flag must appear exactly on the MIN_BURN-th counted cycle. A timer that counted load cycles or started one cycle late would shift both. It also loads an illegal code followed by a no-op before any idle cycle; a design without a sticky error would let the pulse survive. Loads that are never carried out, a start displaced before execution, and a start under a security fault each check that nothing changes outside Run-Test/Idle and that a failed start never opens a pulse. A random run mixes all of these against a bench model.

// File: rtl/isc_pg_pkg.sv
package isc_pg_pkg;
  typedef enum logic [1:0] {
    PK_NONE    = 2'd0,
    PK_START   = 2'd1,
    PK_STOP    = 2'd2,
    PK_ILLEGAL = 2'd3
  } pend_kind_e;

  localparam logic [1:0] RES_PASS = 2'b01;
  localparam logic [1:0] RES_FAIL = 2'b10;

  localparam int SUB_NONE = 0;
  localparam int SUB_DUR  = 1;
  localparam int SUB_SEQ  = 2;
  localparam int SUB_SEC  = 3;
endpackage

// File: rtl/isc_pg_decode.sv
module isc_pg_decode
  import isc_pg_pkg::*;
#(
  parameter int                   IR_W    = 8,
  parameter int                   N_OK    = 4,
  parameter logic [N_OK*IR_W-1:0] OK_LIST = '0,
  parameter logic [IR_W-1:0]      OP_START = '0,
  parameter logic [IR_W-1:0]      OP_STOP  = '0
) (
  input  logic [IR_W-1:0] ir_code,
  input  logic            in_pulse,
  output pend_kind_e      kind
);
  logic [N_OK-1:0] hit;

  generate
    for (genvar i = 0; i < N_OK; i++) begin : g_ok
      assign hit[i] = (ir_code == OK_LIST[i*IR_W +: IR_W]);
    end
  endgenerate

  always_comb begin
    kind = PK_NONE;
    if (ir_code == OP_STOP) begin
      kind = PK_STOP;
    end else if (in_pulse) begin
      kind = (|hit) ? PK_NONE : PK_ILLEGAL;
    end else if (ir_code == OP_START) begin
      kind = PK_START;
    end
  end
endmodule

// File: rtl/isc_pg_burn_timer.sv
module isc_pg_burn_timer #(
  parameter int MIN_BURN = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic expired,
  output logic reach
);
  localparam int TMR_W = $clog2(MIN_BURN + 1);
  localparam logic [TMR_W-1:0] LIMIT  = TMR_W'(MIN_BURN);
  localparam logic [TMR_W-1:0] LAST_B = TMR_W'(MIN_BURN - 1);

  logic [TMR_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign expired = (cnt_q == LIMIT);
  assign reach   = inc && (cnt_q == LAST_B);

  always_comb begin
    cnt_en = clr || (inc && !expired);
    cnt_d  = clr ? '0 : cnt_q + TMR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/isc_pg_status.sv
module isc_pg_status #(
  parameter int SUB_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr,
  input  logic [1:0]       wr_res,
  input  logic             wr_done,
  input  logic [SUB_W-1:0] wr_sub,
  input  logic             set_done,
  output logic [SUB_W+2:0] status
);
  logic [SUB_W+2:0] st_q, st_d;
  logic             st_en;

  always_comb begin
    st_en = clr || wr || set_done;
    st_d  = st_q;
    if (clr) begin
      st_d = '0;
    end else if (wr) begin
      st_d = {wr_sub, wr_done, wr_res};
    end else if (set_done) begin
      st_d[2] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
    end else if (st_en) begin
      st_q <= st_d;
    end
  end

  assign status = st_q;
endmodule

// File: rtl/isc_pulse_guard.sv
module isc_pulse_guard
  import isc_pg_pkg::*;
#(
  parameter int              IR_W      = 8,
  parameter int              SUB_W     = 2,
  parameter int              MIN_BURN  = 1000,
  parameter logic [IR_W-1:0] OP_START  = 8'hE2,
  parameter logic [IR_W-1:0] OP_STOP   = 8'hE3,
  parameter logic [IR_W-1:0] OP_NOOP   = 8'hE0,
  parameter logic [IR_W-1:0] OP_BYPASS = 8'hFF,
  parameter logic [IR_W-1:0] OP_SAMPLE = 8'h01,
  parameter logic [IR_W-1:0] OP_EXTEST = 8'h00
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic             tap_tlr,
  input  logic             tap_rti,
  input  logic             ir_upd,
  input  logic [IR_W-1:0]  ir_code,
  input  logic             sec_fault,
  output logic [SUB_W+2:0] status,
  output logic             pulse_active
);
  localparam int                   N_OK    = 4;
  localparam logic [N_OK*IR_W-1:0] OK_LIST = {OP_NOOP, OP_BYPASS, OP_SAMPLE, OP_EXTEST};

  pend_kind_e       pend_q, pend_d, load_kind;
  logic             act_q, act_d;
  logic             exec;
  logic             tmr_clr, tmr_inc, tmr_expired, tmr_reach;
  logic             st_wr;
  logic [1:0]       st_res;
  logic             st_done;
  logic [SUB_W-1:0] st_sub;

  isc_pg_decode #(
    .IR_W(IR_W), .N_OK(N_OK), .OK_LIST(OK_LIST),
    .OP_START(OP_START), .OP_STOP(OP_STOP)
  ) u_dec (
    .ir_code (ir_code),
    .in_pulse(act_q),
    .kind    (load_kind)
  );

  assign exec = tap_rti && !ir_upd && !tap_tlr;

  always_comb begin
    pend_d = pend_q;
    if (tap_tlr) begin
      pend_d = PK_NONE;
    end else if (ir_upd) begin
      if (pend_q != PK_ILLEGAL) pend_d = load_kind;
    end else if (exec) begin
      pend_d = PK_NONE;
    end
  end

  always_comb begin
    act_d   = act_q;
    tmr_clr = tap_tlr;
    tmr_inc = 1'b0;
    st_wr   = 1'b0;
    st_res  = RES_FAIL;
    st_done = 1'b0;
    st_sub  = SUB_W'(SUB_NONE);
    if (exec) begin
      unique case (pend_q)
        PK_START: begin
          st_wr = 1'b1;
          if (sec_fault) begin
            st_sub = SUB_W'(SUB_SEC);
            act_d  = 1'b0;
          end else begin
            st_res  = RES_PASS;
            act_d   = 1'b1;
            tmr_clr = 1'b1;
          end
        end
        PK_STOP: begin
          st_wr = 1'b1;
          act_d = 1'b0;
          if (!act_q) begin
            st_sub = SUB_W'(SUB_SEQ);
          end else if (tmr_expired) begin
            st_res  = RES_PASS;
            st_done = 1'b1;
          end else begin
            st_sub = SUB_W'(SUB_DUR);
          end
        end
        PK_ILLEGAL: begin
          st_wr  = 1'b1;
          act_d  = 1'b0;
          st_sub = SUB_W'(SUB_SEQ);
        end
        default: tmr_inc = act_q;
      endcase
    end
    if (tap_tlr) act_d = 1'b0;
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      pend_q <= PK_NONE;
      act_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      act_q  <= act_d;
    end
  end

  isc_pg_burn_timer #(.MIN_BURN(MIN_BURN)) u_tmr (
    .clk    (tck),
    .rst_n  (trst_n),
    .clr    (tmr_clr),
    .inc    (tmr_inc),
    .expired(tmr_expired),
    .reach  (tmr_reach)
  );

  isc_pg_status #(.SUB_W(SUB_W)) u_st (
    .clk     (tck),
    .rst_n   (trst_n),
    .clr     (tap_tlr),
    .wr      (st_wr),
    .wr_res  (st_res),
    .wr_done (st_done),
    .wr_sub  (st_sub),
    .set_done(tmr_reach),
    .status  (status)
  );

  assign pulse_active = act_q;
endmodule

// File: rtl/isc_pg_checker.sv
module isc_pg_checker #(
  parameter int SUB_W = 2
) (
  input logic             tck,
  input logic             trst_n,
  input logic             tap_tlr,
  input logic             tap_rti,
  input logic [SUB_W+2:0] status,
  input logic             pulse_active
);
  assert_hold_outside_rti_R2: assert property (@(posedge tck) disable iff (!trst_n)
    (!tap_rti && !tap_tlr) |=> $stable(status));

  assert_tlr_clears_R1: assert property (@(posedge tck) disable iff (!trst_n)
    tap_tlr |=> (status == '0 && !pulse_active));

  assert_no_result_11_R12: assert property (@(posedge tck) disable iff (!trst_n)
    status[1:0] != 2'b11);

  assert_pass_no_sub_R12: assert property (@(posedge tck) disable iff (!trst_n)
    (status[1:0] == 2'b01) |-> (status[SUB_W+2:3] == '0));

  assert_open_in_rti_R3: assert property (@(posedge tck) disable iff (!trst_n)
    $rose(pulse_active) |-> $past(tap_rti));

  assert_close_in_rti_R9: assert property (@(posedge tck) disable iff (!trst_n)
    $fell(pulse_active) |-> ($past(tap_rti) || $past(tap_tlr)));
endmodule

bind isc_pulse_guard isc_pg_checker #(.SUB_W(SUB_W)) u_chk (
  .tck         (tck),
  .trst_n      (trst_n),
  .tap_tlr     (tap_tlr),
  .tap_rti     (tap_rti),
  .status      (status),
  .pulse_active(pulse_active)
);

// File: tb/tb_isc_pulse_guard.sv
module tb_isc_pulse_guard;
  localparam int MINB = 12;
  localparam logic [7:0] C_START = 8'hE2, C_STOP = 8'hE3, C_NOOP = 8'hE0;

  logic       tck = 1'b0;
  logic       trst_n, tlr, rti, upd, sec;
  logic [7:0] code;
  logic [4:0] status;
  logic       pulse_active;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  int         m_pend, m_tmr;
  logic       m_act;
  logic [4:0] m_st;

  always #2 tck = ~tck;

  isc_pulse_guard #(.MIN_BURN(MINB)) dut (
    .tck(tck), .trst_n(trst_n), .tap_tlr(tlr), .tap_rti(rti),
    .ir_upd(upd), .ir_code(code), .sec_fault(sec),
    .status(status), .pulse_active(pulse_active)
  );

  function automatic logic [4:0] st(input int res, input int done, input int sub);
    return {2'(sub), 1'(done), 2'(res)};
  endfunction

  function automatic int classify(input logic [7:0] c, input logic act);
    if (c == C_STOP) return 2;
    if (act) return (c == C_NOOP || c == 8'hFF || c == 8'h01 || c == 8'h00) ? 0 : 3;
    return (c == C_START) ? 1 : 0;
  endfunction

  task automatic m_step(input logic u, input logic [7:0] c, input logic r,
                        input logic t, input logic s);
    if (t) begin
      m_pend = 0; m_act = 0; m_tmr = 0; m_st = '0;
    end else if (u) begin
      if (m_pend != 3) m_pend = classify(c, m_act);
    end else if (r) begin
      case (m_pend)
        1: if (s) begin m_st = st(2, 0, 3); m_act = 0; end
           else begin m_st = st(1, 0, 0); m_act = 1; m_tmr = 0; end
        2: begin
             if (!m_act) m_st = st(2, 0, 2);
             else if (m_tmr >= MINB) m_st = st(1, 1, 0);
             else m_st = st(2, 0, 1);
             m_act = 0;
           end
        3: begin m_st = st(2, 0, 2); m_act = 0; end
        default: if (m_act && m_tmr < MINB) begin
                   m_tmr++;
                   if (m_tmr == MINB) m_st[2] = 1'b1;
                 end
      endcase
      m_pend = 0;
    end
  endtask

  task automatic step(input logic u, input logic [7:0] c, input logic r,
                      input logic t, input logic s);
    @(negedge tck);
    upd = u; code = c; rti = r; tlr = t; sec = s;
    @(posedge tck);
    m_step(u, c, r, t, s);
    #1;
  endtask

  task automatic load(input logic [7:0] c); step(1, c, 0, 0, 0); endtask
  task automatic run_idle(input int n);
    for (int i = 0; i < n; i++) step(0, 8'h00, 1, 0, 0);
  endtask

  task automatic chk(input string req, input logic [4:0] exp_st, input logic exp_act);
    n_run++;
    if (status !== exp_st || pulse_active !== exp_act) begin
      n_fail++;
      $display("FAIL %s: status=%b pulse=%b expected status=%b pulse=%b",
               req, status, pulse_active, exp_st, exp_act);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    trst_n = 0; tlr = 0; rti = 0; upd = 0; sec = 0; code = '0;
    m_pend = 0; m_tmr = 0; m_act = 0; m_st = '0;
    repeat (3) @(posedge tck);
    @(negedge tck); trst_n = 1;
    #1 chk("R1 reset", 5'b0, 0);

    // R7: stop with no open pulse
    load(C_STOP); run_idle(1);
    chk("R7 stop without start", st(2, 0, 2), 0);

    // R3 start, R2 nothing before idle
    load(C_START);
    step(0, 8'h00, 0, 0, 0); step(0, 8'h00, 0, 0, 0);
    chk("R2 no change outside idle", st(2, 0, 2), 0);
    run_idle(1);
    chk("R3 start ok", st(1, 0, 0), 1);

    // R8 permitted loads during pulse
    load(C_NOOP); load(8'hFF); load(8'h01); load(8'h00);
    chk("R8 permitted loads", st(1, 0, 0), 1);
    run_idle(MINB - 1);
    chk("R10 done not yet", st(1, 0, 0), 1);
    run_idle(1);
    chk("R10 done at limit", st(1, 1, 0), 1);
    load(C_STOP); run_idle(1);
    chk("R5 timed stop", st(1, 1, 0), 0);

    // R6 one cycle early
    load(C_START); run_idle(1 + MINB - 1);
    load(C_STOP); run_idle(1);
    chk("R6 early stop", st(2, 0, 1), 0);

    // R4 security fault
    load(C_START); step(0, 8'h00, 1, 0, 1);
    chk("R4 security fault", st(2, 0, 3), 0);

    // R9 sticky illegal
    load(C_START); run_idle(1);
    load(8'h55); load(C_NOOP);
    chk("R9 pending before idle", st(1, 0, 0), 1);
    run_idle(1);
    chk("R9 illegal during pulse", st(2, 0, 2), 0);
    load(C_START); run_idle(1); load(C_START); run_idle(1);
    chk("R9 restart during pulse", st(2, 0, 2), 0);

    // R11 outside pulse
    load(8'h55); run_idle(1);
    chk("R11 other code ignored", st(2, 0, 2), 0);
    load(C_START); load(8'h55); run_idle(1);
    chk("R11 start displaced", st(2, 0, 2), 0);

    // R1 test-logic-reset during pulse
    load(C_START); run_idle(3);
    step(0, 8'h00, 0, 1, 0);
    chk("R1 tlr clears", 5'b0, 0);
    run_idle(2);
    chk("R1 pending discarded", 5'b0, 0);

    // random phase against the model (R2..R12)
    begin
      int seed_dummy;
      seed_dummy = $urandom(32'h1532);
    end
    for (int i = 0; i < 4000; i++) begin
      int sel;
      logic [7:0] c;
      sel = $urandom_range(0, 99);
      case ($urandom_range(0, 7))
        0, 1: c = C_START;
        2, 3: c = C_STOP;
        4:    c = C_NOOP;
        5:    c = 8'hFF;
        6:    c = 8'h01;
        default: c = 8'($urandom);
      endcase
      if (sel < 2)       step(0, 8'h00, 0, 1, 0);
      else if (sel < 30) step(1, c, 0, 0, 0);
      else if (sel < 90) step(0, 8'h00, 1, 0, ($urandom_range(0, 9) == 0));
      else               step(0, 8'h00, 0, 0, 0);
      chk("R12 random vs model", m_st, m_act);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule